// File: doc/BRIEF.md
# Trim Engagement Supervisor

This block decides, once per control frame, whether optimization trim commands may flow to the engine and inlet controllers. It watches a pilot couple pushbutton, an emergency disengage paddle, a power switch, a set of mode-select switches, the landing gear handle with its override, and a single aggregated integrity-failure flag. It drives a coupled flag, a per-frame trim-enable strobe, three cockpit lamps and a code that records why the last disengagement happened.

Engagement has exactly one entry path: a pilot press of the couple button, accepted at a frame tick while every criterion holds. Disengagement has many: a second press, the paddle, or loss of any criterion when it is re-checked at a frame tick. The frame tick is a one-cycle strobe from a periodic timer (nominally 20 Hz). The paddle acts without waiting for a tick. Both pushbutton inputs are asynchronous and pass through a synchronizer and an edge detector, so a held button counts as one press.

Top module: `trim_supervisor`

## Requirements
- R1: After synchronous reset, `coupled`, `trim_en`, `lamp_coupled` and `lamp_fault` are 0 and `last_reason` is 0 (none).
- R2: The block couples only at a `frame_tick` cycle when a button press is pending (or its rising edge arrives in that cycle) and all criteria hold. A press while any criterion fails is discarded and the block stays uncoupled. Nothing else can couple it.
- R3: A press accepted at a tick while coupled uncouples the block and sets `last_reason` to 2 (button). Every uncouple writes a nonzero reason code.
- R4: Each button input passes through two synchronizing flops before edge detection. A button held over many cycles and several ticks causes exactly one toggle.
- R5: While the synchronized paddle is high, the block is forced uncoupled in the next cycle, with no tick needed, and pending presses are discarded. If it was coupled, `last_reason` becomes 1 (paddle).
- R6: At a tick while coupled, a failed criterion uncouples the block. The reason is picked by priority: power off (3), then integrity failure (6), then mode fault (4), then gear down without override (5). Gear down with `gear_override` high is not a fault.
- R7: The mode criterion holds only when exactly one bit of `mode_sel` is set. Zero bits or several bits are a mode fault.
- R8: `trim_en` is a one-cycle pulse in the cycle after each tick at which the block ends coupled (newly or still). It is never high at any other time.
- R9: `lamp_trims` equals `power_on` AND (`mode_sel` & `TRIM_MODE_MASK` != 0), combinationally; default mask is 4'b0011. `lamp_coupled` follows `coupled`.
- R10: `lamp_fault` sets when an integrity failure causes an uncouple. It stays set across later ticks until `power_on` is low, and clears in the cycle after that.
- R11: Criteria are sampled only at ticks. A criterion that fails between ticks does not uncouple the block before the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe marking a control frame |
| couple_btn | input | 1 | Raw pilot couple/uncouple pushbutton |
| paddle_sw | input | 1 | Raw emergency disengage paddle |
| power_on | input | 1 | Power switch on |
| mode_sel | input | NUM_MODES | Mode-select switches |
| gear_down | input | 1 | Landing gear handle down |
| gear_override | input | 1 | Gear-down override |
| integrity_fail | input | 1 | Aggregated integrity failure |
| coupled | output | 1 | Block engaged |
| trim_en | output | 1 | Per-frame trim-enable strobe |
| lamp_trims | output | 1 | Trim-sending mode selected lamp |
| lamp_coupled | output | 1 | Coupled lamp |
| lamp_fault | output | 1 | Latched integrity-fault lamp |
| last_reason | output | 3 | Last uncouple reason: 0 none, 1 paddle, 2 button, 3 power, 4 mode, 5 gear, 6 integrity |

## Verification
The hardest cases to reach are combined failures at one tick, where the reason priority and the fault latch interact. Examples are integrity failure together with a mode fault, or power off together with integrity failure. Random stimulus rarely lines these up while coupled. Directed sequences therefore first couple the block, then raise several criteria between ticks so they fail together, and check the reason code and lamp at the next tick. A held button that spans several ticks and a press refused for a bad mode are also driven directly. Long random runs with rare input flips then compare every output, every cycle, against a bench model.

// File: rtl/trim_sup_pkg.sv
package trim_sup_pkg;

    typedef enum logic [2:0] {
        RSN_NONE   = 3'd0,
        RSN_PADDLE = 3'd1,
        RSN_BUTTON = 3'd2,
        RSN_POWER  = 3'd3,
        RSN_MODE   = 3'd4,
        RSN_GEAR   = 3'd5,
        RSN_INTEG  = 3'd6
    } reason_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_ENGAGED = 1'b1
    } eng_state_e;

    typedef struct packed {
        logic power_ok;
        logic integ_ok;
        logic mode_ok;
        logic gear_ok;
    } crit_t;

    function automatic logic crit_all(input crit_t c);
        return c.power_ok & c.integ_ok & c.mode_ok & c.gear_ok;
    endfunction

    // Priority: power, integrity, mode, gear
    function automatic reason_e pick_reason(input crit_t c);
        if (!c.power_ok)      return RSN_POWER;
        else if (!c.integ_ok) return RSN_INTEG;
        else if (!c.mode_ok)  return RSN_MODE;
        else                  return RSN_GEAR;
    endfunction

endpackage

// File: rtl/trim_sup_sync.sv
module trim_sup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] stg;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg  <= '0;
            prev <= 1'b0;
        end else begin
            stg  <= {stg[STAGES-2:0], raw};
            prev <= stg[STAGES-1];
        end
    end

    assign level = stg[STAGES-1];
    assign rise  = stg[STAGES-1] & ~prev;
endmodule

// File: rtl/trim_sup_criteria.sv
module trim_sup_criteria
    import trim_sup_pkg::*;
#(
    parameter int NUM_MODES = 4
) (
    input  logic                 power_on,
    input  logic [NUM_MODES-1:0] mode_sel,
    input  logic                 gear_down,
    input  logic                 gear_override,
    input  logic                 integrity_fail,
    output crit_t                crit
);
    logic single_mode;

    always_comb begin
        single_mode   = (mode_sel != '0) &&
                        ((mode_sel & (mode_sel - 1'b1)) == '0);
        crit.power_ok = power_on;
        crit.integ_ok = ~integrity_fail;
        crit.mode_ok  = single_mode;
        crit.gear_ok  = ~gear_down | gear_override;
    end
endmodule

// File: rtl/trim_sup_core.sv
module trim_sup_core
    import trim_sup_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    frame_tick,
    input  logic    btn_rise,
    input  logic    paddle,
    input  logic    power_on,
    input  crit_t   crit,
    output logic    engaged,
    output logic    trim_pulse,
    output logic    fault_latch,
    output reason_e reason
);
    eng_state_e state;
    logic       pend;
    logic       press;
    logic       ok_all;
    reason_e    fail_rsn;

    assign press    = pend | btn_rise;
    assign ok_all   = crit_all(crit);
    assign fail_rsn = pick_reason(crit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            pend        <= 1'b0;
            reason      <= RSN_NONE;
            fault_latch <= 1'b0;
            trim_pulse  <= 1'b0;
        end else begin
            trim_pulse <= 1'b0;
            if (paddle) begin
                if (state == ST_ENGAGED) reason <= RSN_PADDLE;
                state <= ST_IDLE;
                pend  <= 1'b0;
            end else if (frame_tick) begin
                pend <= 1'b0;
                if (state == ST_ENGAGED) begin
                    if (!ok_all) begin
                        state  <= ST_IDLE;
                        reason <= fail_rsn;
                        if (fail_rsn == RSN_INTEG) fault_latch <= 1'b1;
                    end else if (press) begin
                        state  <= ST_IDLE;
                        reason <= RSN_BUTTON;
                    end else begin
                        trim_pulse <= 1'b1;
                    end
                end else if (press && ok_all) begin
                    state      <= ST_ENGAGED;
                    trim_pulse <= 1'b1;
                end
            end else if (btn_rise) begin
                pend <= 1'b1;
            end
            if (!power_on) fault_latch <= 1'b0;
        end
    end

    assign engaged = (state == ST_ENGAGED);
endmodule

// File: rtl/trim_supervisor.sv
module trim_supervisor
    import trim_sup_pkg::*;
#(
    parameter int                   NUM_MODES      = 4,
    parameter logic [NUM_MODES-1:0] TRIM_MODE_MASK = 4'b0011,
    parameter int                   SYNC_STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_tick,
    input  logic                 couple_btn,
    input  logic                 paddle_sw,
    input  logic                 power_on,
    input  logic [NUM_MODES-1:0] mode_sel,
    input  logic                 gear_down,
    input  logic                 gear_override,
    input  logic                 integrity_fail,
    output logic                 coupled,
    output logic                 trim_en,
    output logic                 lamp_trims,
    output logic                 lamp_coupled,
    output logic                 lamp_fault,
    output logic [2:0]           last_reason
);
    localparam int NUM_BTN = 2;

    logic [NUM_BTN-1:0] raw_btn;
    logic [NUM_BTN-1:0] lvl_btn;
    logic [NUM_BTN-1:0] rise_btn;
    logic               paddle_s;
    crit_t              crit;
    reason_e            reason;

    assign raw_btn = {paddle_sw, couple_btn};

    for (genvar i = 0; i < NUM_BTN; i++) begin : g_sync
        trim_sup_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_btn[i]),
            .level (lvl_btn[i]),
            .rise  (rise_btn[i])
        );
    end

    assign paddle_s = lvl_btn[1];

    trim_sup_criteria #(.NUM_MODES(NUM_MODES)) u_crit (
        .power_on       (power_on),
        .mode_sel       (mode_sel),
        .gear_down      (gear_down),
        .gear_override  (gear_override),
        .integrity_fail (integrity_fail),
        .crit           (crit)
    );

    trim_sup_core u_core (
        .clk         (clk),
        .rst         (rst),
        .frame_tick  (frame_tick),
        .btn_rise    (rise_btn[0]),
        .paddle      (paddle_s),
        .power_on    (power_on),
        .crit        (crit),
        .engaged     (coupled),
        .trim_pulse  (trim_en),
        .fault_latch (lamp_fault),
        .reason      (reason)
    );

    assign last_reason  = reason;
    assign lamp_coupled = coupled;
    assign lamp_trims   = power_on && ((mode_sel & TRIM_MODE_MASK) != '0);
endmodule

// File: rtl/trim_supervisor_chk.sv
module trim_supervisor_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_tick,
    input logic       power_on,
    input logic       paddle_s,
    input logic       coupled,
    input logic       trim_en,
    input logic       lamp_fault,
    input logic [2:0] last_reason
);
    assert_couple_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (!coupled && !frame_tick) |=> !coupled);

    assert_reason_written_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(coupled) |-> (last_reason != 3'd0));

    assert_paddle_drop_R5: assert property (@(posedge clk) disable iff (rst)
        paddle_s |=> !coupled);

    assert_strobe_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> !trim_en);

    assert_strobe_coupled_R8: assert property (@(posedge clk) disable iff (rst)
        trim_en |-> coupled);

    assert_fault_clear_R10: assert property (@(posedge clk) disable iff (rst)
        !power_on |=> !lamp_fault);

    assert_fault_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(lamp_fault) |-> (last_reason == 3'd6));
endmodule

bind trim_supervisor trim_supervisor_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_tick  (frame_tick),
    .power_on    (power_on),
    .paddle_s    (paddle_s),
    .coupled     (coupled),
    .trim_en     (trim_en),
    .lamp_fault  (lamp_fault),
    .last_reason (last_reason)
);

// File: tb/trim_supervisor_test.sv
module trim_supervisor_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_tick = 0, couple_btn = 0, paddle_sw = 0, power_on = 0;
    logic [3:0] mode_sel = 4'b0000;
    logic gear_down = 0, gear_override = 0, integrity_fail = 0;
    logic coupled, trim_en, lamp_trims, lamp_coupled, lamp_fault;
    logic [2:0] last_reason;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    // model state
    logic mb1 = 0, mb2 = 0, mbp = 0, mp1 = 0, mp2 = 0;
    logic m_cpl = 0, m_pend = 0, m_fault = 0, m_trim = 0;
    logic [2:0] m_rsn = 0;

    always #10 clk = ~clk;

    trim_supervisor uut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .couple_btn(couple_btn),
        .paddle_sw(paddle_sw), .power_on(power_on), .mode_sel(mode_sel),
        .gear_down(gear_down), .gear_override(gear_override),
        .integrity_fail(integrity_fail), .coupled(coupled), .trim_en(trim_en),
        .lamp_trims(lamp_trims), .lamp_coupled(lamp_coupled),
        .lamp_fault(lamp_fault), .last_reason(last_reason)
    );

    function automatic logic [2:0] exp_fail_code();
        logic one_mode = (mode_sel == 4'b0001) || (mode_sel == 4'b0010) ||
                         (mode_sel == 4'b0100) || (mode_sel == 4'b1000);
        if (!power_on) return 3'd3;
        if (integrity_fail) return 3'd6;
        if (!one_mode) return 3'd4;
        if (gear_down && !gear_override) return 3'd5;
        return 3'd0;
    endfunction

    task automatic model_step();
        logic rise = mb2 & ~mbp;
        logic press = m_pend | rise;
        logic [2:0] f = exp_fail_code();
        if (rst) begin
            m_cpl = 0; m_pend = 0; m_fault = 0; m_trim = 0; m_rsn = 0;
            mb1 = 0; mb2 = 0; mbp = 0; mp1 = 0; mp2 = 0;
            return;
        end
        m_trim = 0;
        if (mp2) begin
            if (m_cpl) m_rsn = 3'd1;
            m_cpl = 0; m_pend = 0;
        end else if (frame_tick) begin
            m_pend = 0;
            if (m_cpl) begin
                if (f != 0) begin
                    m_cpl = 0; m_rsn = f;
                    if (f == 3'd6) m_fault = 1;
                end else if (press) begin
                    m_cpl = 0; m_rsn = 3'd2;
                end else m_trim = 1;
            end else if (press && f == 0) begin
                m_cpl = 1; m_trim = 1;
            end
        end else if (rise) m_pend = 1;
        if (!power_on) m_fault = 0;
        mbp = mb2; mb2 = mb1; mb1 = couple_btn;
        mp2 = mp1; mp1 = paddle_sw;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare_all();
        logic ex_trims = power_on && ((mode_sel & 4'b0011) != 0);
        checks++;
        if (coupled !== m_cpl || trim_en !== m_trim || lamp_fault !== m_fault ||
            last_reason !== m_rsn || lamp_coupled !== m_cpl || lamp_trims !== ex_trims) begin
            errors++;
            $display("FAIL %s: actual cpl=%0b trim=%0b flt=%0b rsn=%0d lc=%0b lt=%0b expected cpl=%0b trim=%0b flt=%0b rsn=%0d lc=%0b lt=%0b",
                     tag, coupled, trim_en, lamp_fault, last_reason, lamp_coupled, lamp_trims,
                     m_cpl, m_trim, m_fault, m_rsn, m_cpl, ex_trims);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic tick_frame();
        frame_tick = 1; cycle(); frame_tick = 0;
    endtask

    task automatic press_btn();
        couple_btn = 1; repeat (4) cycle();
        couple_btn = 0; repeat (3) cycle();
    endtask

    task automatic good_inputs();
        power_on = 1; mode_sel = 4'b0001; gear_down = 0; gear_override = 0;
        integrity_fail = 0; cycle();
    endtask

    task automatic engage();
        good_inputs(); press_btn(); tick_frame(); cycle();
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        rst = 1; repeat (3) cycle();
        rst = 0; cycle();
        tag = "R1 reset";
        chk("R1 coupled", coupled, 0);
        chk("R1 reason", last_reason, 0);
        chk("R1 fault", lamp_fault, 0);

        tag = "R2 couple";
        good_inputs();
        chk("R9 trims lamp", lamp_trims, 1);
        press_btn();
        chk("R2 no couple before tick", coupled, 0);
        tick_frame();
        chk("R2 coupled after tick", coupled, 1);
        chk("R8 strobe after tick", trim_en, 1);
        cycle();
        chk("R8 strobe single cycle", trim_en, 0);
        chk("R9 coupled lamp", lamp_coupled, 1);

        tag = "R4 held button";
        couple_btn = 1; repeat (4) cycle();
        tick_frame(); repeat (5) cycle(); tick_frame(); repeat (5) cycle();
        couple_btn = 0; repeat (3) cycle(); tick_frame();
        chk("R4 one toggle", coupled, 0);
        chk("R3 button reason", last_reason, 2);

        tag = "R2 refused";
        mode_sel = 4'b0000; cycle();
        press_btn(); tick_frame(); cycle();
        chk("R2 press ignored bad mode", coupled, 0);
        mode_sel = 4'b0100; cycle();
        chk("R9 trims lamp off for non-trim mode", lamp_trims, 0);
        tick_frame();
        chk("R2 discarded press not reused", coupled, 0);

        tag = "R7 mode";
        engage();
        mode_sel = 4'b0011; repeat (3) cycle();
        chk("R11 held until tick", coupled, 1);
        tick_frame();
        chk("R7 multi mode uncouple", coupled, 0);
        chk("R7 mode reason", last_reason, 4);

        tag = "R6 gear";
        engage();
        gear_down = 1; gear_override = 1; cycle(); tick_frame();
        chk("R6 override keeps coupled", coupled, 1);
        gear_override = 0; cycle(); tick_frame();
        chk("R6 gear reason", last_reason, 5);

        tag = "R10 integrity";
        engage();
        integrity_fail = 1; mode_sel = 4'b0000; cycle(); tick_frame();
        chk("R6 integrity over mode", last_reason, 6);
        chk("R10 fault lamp set", lamp_fault, 1);
        integrity_fail = 0; mode_sel = 4'b0001; cycle(); tick_frame(); cycle();
        chk("R10 fault lamp latched", lamp_fault, 1);
        power_on = 0; cycle();
        chk("R10 fault cleared by power off", lamp_fault, 0);

        tag = "R6 power";
        engage();
        power_on = 0; integrity_fail = 1; cycle(); tick_frame();
        chk("R6 power first", last_reason, 3);
        chk("R10 no fault on power reason", lamp_fault, 0);

        tag = "R5 paddle";
        engage();
        paddle_sw = 1; repeat (3) cycle();
        chk("R5 paddle uncouple without tick", coupled, 0);
        chk("R5 paddle reason", last_reason, 1);
        press_btn(); tick_frame();
        chk("R5 press blocked by paddle", coupled, 0);
        paddle_sw = 0; repeat (3) cycle(); tick_frame();
        chk("R5 discarded press", coupled, 0);

        tag = "R8 random";
        good_inputs();
        for (int n = 0; n < 6000; n++) begin
            frame_tick = (n % 10 == 0);
            if ($urandom_range(0, 15) == 0) couple_btn = ~couple_btn;
            if ($urandom_range(0, 199) == 0) paddle_sw = ~paddle_sw;
            if ($urandom_range(0, 99) == 0) power_on = ~power_on;
            if ($urandom_range(0, 79) == 0)
                mode_sel = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'(1 << $urandom_range(0, 3));
            if ($urandom_range(0, 79) == 0) gear_down = ~gear_down;
            if ($urandom_range(0, 79) == 0) gear_override = ~gear_override;
            if ($urandom_range(0, 119) == 0) integrity_fail = ~integrity_fail;
            if (paddle_sw && $urandom_range(0, 3) == 0) paddle_sw = 0;
            cycle();
        end
        frame_tick = 0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule